// File: doc/BRIEF.md
# Sequential Restoring Binary Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor, one quotient bit per clock. On an accepted start it records the negated divisor and places the dividend in the low half of a combined remainder:quotient register. Each step shifts that pair left by one bit and adds the negated divisor to the upper half, which is a trial subtraction. A negative trial result keeps the shifted value and enters a 0 quotient bit. A non-negative result is kept and enters a 1. After W steps the low half holds the quotient and the upper half holds the remainder.

Three operand cases skip the iteration and finish in one clock. A zero divisor raises an error flag. Equal operands give quotient 1 and remainder 0. A divisor larger than the dividend gives quotient 0, with the dividend as the remainder. The results and the error flag stay on the outputs until the next accepted start. A caller pulses `start` while `busy` is low and then waits for the one-cycle `done` pulse.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `div_err`, `quotient` and `remainder` are all zero.
- R2: A start with divisor 0 gives `done` with `div_err`=1 in the clock after the start edge, and `busy` never rises. The quotient and remainder are unspecified in this case.
- R3: A start with a nonzero divisor equal to the dividend gives `done` in the next clock, with quotient 1, remainder 0 and `div_err`=0.
- R4: A start with the divisor greater than the dividend gives `done` in the next clock, with quotient 0, remainder equal to the dividend and `div_err`=0.
- R5: Any other start raises `busy` in the next clock. `done` appears exactly W+1 clocks after the start edge, and `busy` falls in the same clock.
- R6: Every finished division without error satisfies dividend = quotient*divisor + remainder, with remainder < divisor.
- R7: A start while `busy` is high is ignored. The running division finishes with the result and latency of its original operands.
- R8: `done` is high for one clock only. `quotient`, `remainder` and `div_err` stay unchanged until the next accepted start.
- R9: `busy` and `done` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; accepted only while not busy |
| dividend | input | W | Unsigned dividend, sampled at the accepted start |
| divisor | input | W | Unsigned divisor, sampled at the accepted start |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-clock pulse when results become valid |
| div_err | output | 1 | Divisor was zero for the last accepted start |
| quotient | output | W | Quotient of the last division |
| remainder | output | W | Remainder of the last division |

## Verification
Each step decides one quotient bit, so a wrong decision or a wrong restore shows up at the ports only when `done` rises. It appears as a quotient/remainder pair that breaks the division identity, or as a remainder that is not smaller than the divisor. A step counter that is off by one moves `done` away from clock W+1 after the start edge. Operands taken in by a start while busy change the final pair, and an early-exit decision that is not made shows up as a W+1 latency where a one-clock answer is required. All of these faults therefore appear within W+1 clocks of the start that triggers them.

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    a_q, m_q;
  logic [W-1:0]  q_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, err_q;

  wire accept  = start && !busy_q;
  wire dv_zero = (divisor == '0);
  wire dv_eq   = (divisor == dividend);
  wire dv_gt   = (divisor > dividend);

  wire [W:0]   a_sh  = {a_q[W-1:0], q_q[W-1]};
  wire [W:0]   trial = a_sh + m_q;
  wire         neg   = trial[W];
  wire [W:0]   a_nx  = neg ? a_sh : trial;
  wire [W-1:0] q_nx  = {q_q[W-2:0], ~neg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      m_q    <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        m_q   <= -{1'b0, divisor};
        err_q <= 1'b0;
        if (dv_zero) begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
          q_q    <= '1;
          a_q    <= {1'b0, dividend};
        end else if (dv_eq) begin
          done_q <= 1'b1;
          q_q    <= {{(W-1){1'b0}}, 1'b1};
          a_q    <= '0;
        end else if (dv_gt) begin
          done_q <= 1'b1;
          q_q    <= '0;
          a_q    <= {1'b0, dividend};
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(W);
          q_q    <= dividend;
          a_q    <= '0;
        end
      end else if (busy_q) begin
        a_q   <= a_nx;
        q_q   <= q_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign div_err   = err_q;
  assign quotient  = q_q;
  assign remainder = a_q[W-1:0];

  wire [W:0] held_divisor = -m_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !div_err && quotient == '0 && remainder == '0);

  p_zero_divisor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dv_zero) |=> done && div_err && !busy);

  p_equal_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dv_zero && dv_eq) |=> done && !div_err && quotient == W'(1) && remainder == '0);

  p_larger_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dv_gt) |=> done && !div_err && quotient == '0 && remainder == $past(dividend));

  p_busy_ends_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_remainder_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err) |-> {1'b0, remainder} < held_divisor);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(held_divisor));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(quotient) && $stable(remainder) && $stable(div_err));

  p_no_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done, div_err;
  logic [W-1:0] quotient, remainder;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  restoring_divider #(.W(W)) u_restoring_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input int dd, input int dv);
    if (dv == 0 || dv >= dd) return 1;
    return W + 1;
  endfunction

  task automatic run_div(input int dd, input int dv, input bit poke);
    int lat;
    int exp_lat;
    @(negedge clk);
    dividend = W'(dd);
    divisor  = W'(dv);
    start    = 1'b1;
    exp_lat  = exp_latency(dd, dv);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (exp_lat > 1) chk(busy === 1'b1, "R5 busy after start", busy, 1);
    while (!done && lat < W + 6) begin
      if (poke && lat == 2) begin
        dividend = 8'd9;
        divisor  = 8'd9;
        start    = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (dv == 0) begin
      chk(lat == 1, "R2 latency", lat, 1);
      chk(div_err === 1'b1, "R2 error flag", div_err, 1);
    end else begin
      chk(lat == exp_lat, poke ? "R7 latency" : "R5 latency", lat, exp_lat);
      chk(div_err === 1'b0, "R6 no error", div_err, 0);
      chk(quotient == W'(dd / dv), poke ? "R7 quotient" : "R6 quotient", quotient, dd / dv);
      chk(remainder == W'(dd % dv), poke ? "R7 remainder" : "R6 remainder", remainder, dd % dv);
      if (dv == dd) chk(quotient == 1 && remainder == 0, "R3 equal operands", quotient, 1);
      if (dv > dd)  chk(quotient == 0 && remainder == W'(dd), "R4 larger divisor", remainder, dd);
    end
    chk(!busy, "R9 busy low with done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hq, hr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !div_err, "R1 reset flags", {busy, done, div_err}, 0);
    chk(quotient == 0 && remainder == 0, "R1 reset data", quotient, 0);
    rst_n = 1'b1;

    run_div(100, 0, 0);
    run_div(0, 0, 0);
    run_div(77, 77, 0);
    run_div(1, 1, 0);
    run_div(5, 200, 0);
    run_div(0, 5, 0);
    run_div(255, 1, 0);
    run_div(255, 254, 0);
    run_div(200, 7, 0);
    run_div(200, 3, 1);

    hq = quotient;
    hr = remainder;
    @(negedge clk);
    chk(!done, "R8 done one clock", done, 0);
    repeat (3) @(negedge clk);
    chk(quotient == hq && remainder == hr, "R8 hold quotient/remainder", quotient, hq);

    for (int i = 0; i < 400; i++) begin
      int dd, dv, mode;
      dd = int'($urandom % 256);
      mode = int'($urandom % 4);
      case (mode)
        0: dv = int'($urandom % 256);
        1: dv = 1 + int'($urandom % 15);
        2: dv = dd;
        default: dv = 1 + int'($urandom % 255);
      endcase
      run_div(dd, dv, (i % 37) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule